// File: doc/BRIEF.md
# Coarse-Grain Two-Thread Switch Controller

This controller lets two hardware threads share one single-issue, in-order pipeline with the stages IF, ID, EX, MEM and WB. Only one thread fetches at a time. The running thread keeps the pipeline until it suffers a long-latency cache miss. The miss can be an instruction-fetch miss in IF or a data-access miss in MEM. The controller then suspends that thread, records where it must restart, and hands fetch to the other thread if that thread can run. A missing fill normally takes about 20 cycles, while the switch loses a single fetch slot.

The block holds a program counter and a waiting flag for each thread. It drives the fetch address, a fetch-valid flag and the active thread number, which the datapath uses to pick its register file and address mapping. It also tracks which thread owns the instruction in each of IF, ID, EX and MEM. On a data miss it uses that record to abort the load or store that missed, together with every younger instruction of the same thread. The aborted load or store is replayed from its own PC. When the memory system reports that a thread's fill is done, that thread becomes runnable again. It does not interrupt the running thread. If both threads are waiting, fetch idles until one of them is released.

The datapath supplies the following address of the running thread on `next_pc_i`. This is the sequential successor or a resolved branch target. The pipeline is assumed to advance every cycle.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: After reset, thread 0 is active, `fetch_valid_o` is 1, `fetch_pc_o` equals `RST_PC0` and `squash_o` is 0. Thread 1 is not waiting and will start at `RST_PC1` the first time it is switched to.
- R2: Whenever a fetch is valid and `squash_o[0]` is 0, the same thread fetches from the value `next_pc_i` held in the previous cycle.
- R3: `imiss_i` during a valid fetch sets `squash_o[0]` (bit 0 = IF) in that cycle and suspends the active thread with the missed fetch address as its resume PC. In the next cycle the other thread, if it is not waiting, fetches at its saved PC.
- R4: `dmiss_i` while MEM holds a valid instruction sets `squash_o[3]` (bit 3 = MEM). It also sets bits 2 (EX), 1 (ID) and 0 (IF) for exactly those stages holding a valid instruction of the same thread.
- R5: On an accepted data miss, the missing thread's resume PC becomes `dmiss_pc_i` and the thread waits. If that thread was already suspended, the active thread keeps running and no switch happens.
- R6: `dmiss_i` while MEM holds no valid instruction has no effect: no squash, no switch, and no change to any resume PC.
- R7: When a data miss of the active thread and `imiss_i` occur in the same cycle, the data miss wins: the resume PC is `dmiss_pc_i`, not the fetch address.
- R8: `fill_done_i[t]` releases waiting thread t but never preempts the running thread. The released thread runs at the next switch.
- R9: If a switch finds the other thread waiting, `fetch_valid_o` drops to 0 and no IF squash is raised. The first thread to be released then resumes in the next cycle, with thread 0 chosen when both are released together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imiss_i | input | 1 | The fetch in IF this cycle missed the instruction cache |
| dmiss_i | input | 1 | The access in MEM this cycle missed the data cache |
| dmiss_pc_i | input | PC_W | PC of the load or store that missed in MEM |
| fill_done_i | input | 2 | Per-thread pulse: the outstanding fill of that thread has completed |
| next_pc_i | input | PC_W | Following fetch address of the running thread |
| fetch_pc_o | output | PC_W | Address fetched this cycle |
| fetch_valid_o | output | 1 | A real fetch is issued this cycle (0 = bubble) |
| active_tid_o | output | 1 | Thread that owns the fetch |
| squash_o | output | 4 | Abort mask: bit 0 IF, bit 1 ID, bit 2 EX, bit 3 MEM |

## Verification
The hardest case to reach is a data miss on an older instruction of a thread that has already been suspended by an instruction miss. There, the squash mask must cover only that thread's stages, no switch may occur, and the thread's resume PC must move back to the load. The stimulus reaches it by letting thread 0 fetch three instructions and then raising an instruction miss. In the next cycle it reports a data miss for thread 0's first instruction, which is then in MEM. The expected mask covers MEM and EX but not the already squashed ID or thread 1's IF slot. Finally, both threads are driven into the waiting state and thread 0 is released, so the bench can observe that it restarts at the load's PC.

// File: rtl/cgmt_pkg.sv
// Shared constants and types for the coarse-grain thread switch controller.
// Assumes exactly two thread contexts and a five-stage in-order pipeline
// whose first four stages can be aborted.
package cgmt_pkg;
    localparam int NTHR   = 2;
    localparam int TID_W  = $clog2(NTHR);
    localparam int NSQ    = 4;           // abortable stages IF..MEM
    localparam int SQ_IF  = 0;
    localparam int SQ_ID  = 1;
    localparam int SQ_EX  = 2;
    localparam int SQ_MEM = 3;

    typedef logic [TID_W-1:0] tid_t;

    // Ownership tag carried alongside one pipeline slot
    typedef struct packed {
        logic vld;
        tid_t tid;
    } slot_t;
endpackage

// File: rtl/cgmt_thread_ctx.sv
// One thread context: program counter and the waiting-on-fill flag.
// The PC advances on an unsquashed fetch, or is overwritten with the PC
// of a load/store that missed. The waiting flag is set on any miss of
// this thread and cleared by its fill pulse; setting wins.
module cgmt_thread_ctx #(
    parameter int              PC_W   = 32,
    parameter logic [PC_W-1:0] RST_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    input  logic [PC_W-1:0] next_pc_i,
    input  logic            cap_i,
    input  logic [PC_W-1:0] cap_pc_i,
    input  logic            set_wait_i,
    input  logic            fill_i,
    output logic [PC_W-1:0] pc_o,
    output logic            wait_o
);
    logic [PC_W-1:0] pc_q;
    logic            wait_q;

    // Resume/fetch PC register of this thread
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RST_PC;
        end else if (cap_i) begin
            pc_q <= cap_pc_i;
        end else if (adv_i) begin
            pc_q <= next_pc_i;
        end
    end

    // Waiting flag: raised by a miss, dropped by the fill pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= 1'b0;
        end else if (set_wait_i) begin
            wait_q <= 1'b1;
        end else if (fill_i) begin
            wait_q <= 1'b0;
        end
    end

    assign pc_o   = pc_q;
    assign wait_o = wait_q;
endmodule

// File: rtl/cgmt_stage_tags.sv
// Ownership tags for ID, EX and MEM plus the abort mask generator.
// Assumes the pipeline advances every cycle, so the tag of the fetch in
// IF reaches MEM three cycles later. A data miss is accepted only when
// MEM holds a valid tag. It aborts MEM and every younger slot of the same
// thread. An accepted instruction miss aborts the IF slot.
module cgmt_stage_tags
    import cgmt_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  slot_t          if_slot_i,
    input  logic           dmiss_i,
    input  logic           imiss_take_i,
    output logic           dmiss_vld_o,
    output tid_t           dmiss_tid_o,
    output logic [NSQ-1:0] squash_o
);
    // Slots in stage order: index SQ_IF is the live fetch, the rest are held
    slot_t slot [NSQ];
    slot_t held_q [NSQ-1];

    assign slot[SQ_IF] = if_slot_i;

    genvar s;
    generate
        for (s = 1; s < NSQ; s++) begin : g_view
            assign slot[s] = held_q[s-1];
        end
    endgenerate

    assign dmiss_vld_o = dmiss_i & slot[SQ_MEM].vld;
    assign dmiss_tid_o = slot[SQ_MEM].tid;

    // Abort mask: MEM on an accepted data miss, younger slots of its thread
    always_comb begin
        for (int k = 0; k < NSQ; k++) begin
            squash_o[k] = dmiss_vld_o && slot[k].vld && (slot[k].tid == dmiss_tid_o);
        end
        squash_o[SQ_IF] = squash_o[SQ_IF] | imiss_take_i;
    end

    // Advance tags one stage per cycle, dropping aborted slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NSQ-1; k++) begin
                held_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < NSQ-1; k++) begin
                held_q[k].vld <= slot[k].vld & ~squash_o[k];
                held_q[k].tid <= slot[k].tid;
            end
        end
    end
endmodule

// File: rtl/cgmt_sched.sv
// Fetch owner selection. It keeps the active thread and a running flag.
// A miss of the active thread switches to the other thread if that thread
// is not waiting (counting a fill arriving this cycle), and otherwise stops
// fetch. While stopped, the first released thread takes over, with thread 0
// first on a tie. Fills never preempt a running thread. A data miss
// outranks an instruction miss in the same cycle.
module cgmt_sched
    import cgmt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dmiss_vld_i,
    input  tid_t            dmiss_tid_i,
    input  logic            imiss_i,
    input  logic [NTHR-1:0] fill_i,
    input  logic [NTHR-1:0] wait_i,
    output tid_t            act_o,
    output logic            run_o,
    output logic            imiss_take_o,
    output logic [NTHR-1:0] set_wait_o
);
    tid_t            act_q, act_d;
    logic            run_q, run_d;
    logic [NTHR-1:0] wait_nx;
    tid_t            other;

    assign other = ~act_q;

    // Miss acceptance and next-cycle waiting picture per thread
    always_comb begin
        imiss_take_o = run_q & imiss_i & ~(dmiss_vld_i & (dmiss_tid_i == act_q));
        for (int t = 0; t < NTHR; t++) begin
            set_wait_o[t] = (dmiss_vld_i && (dmiss_tid_i == tid_t'(t)))
                          || (imiss_take_o && (act_q == tid_t'(t)));
            wait_nx[t]    = set_wait_o[t] | (wait_i[t] & ~fill_i[t]);
        end
    end

    // Next owner: switch on own miss, idle if blocked, wake lowest released
    always_comb begin
        act_d = act_q;
        run_d = run_q;
        if (run_q) begin
            if (set_wait_o[act_q]) begin
                if (!wait_nx[other]) begin
                    act_d = other;
                end else begin
                    run_d = 1'b0;
                end
            end
        end else begin
            if (!wait_nx[0]) begin
                act_d = tid_t'(0);
                run_d = 1'b1;
            end else if (!wait_nx[1]) begin
                act_d = tid_t'(1);
                run_d = 1'b1;
            end
        end
    end

    // Owner and running state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= tid_t'(0);
            run_q <= 1'b1;
        end else begin
            act_q <= act_d;
            run_q <= run_d;
        end
    end

    assign act_o = act_q;
    assign run_o = run_q;
endmodule

// File: rtl/cgmt_switch_ctrl.sv
// Top of the coarse-grain thread switch controller. It combines two thread
// contexts, the owner selector and the stage tag tracker. The fetch address
// is the active thread's PC, and fetch is valid while a thread runs. The
// datapath supplies the following address on next_pc_i, and the PC of a
// missing load/store on dmiss_pc_i. Assumes no stalls other than the
// aborts driven here.
module cgmt_switch_ctrl
    import cgmt_pkg::*;
#(
    parameter int              PC_W    = 32,
    parameter logic [PC_W-1:0] RST_PC0 = 32'h0000_1000,
    parameter logic [PC_W-1:0] RST_PC1 = 32'h0000_8000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            imiss_i,
    input  logic            dmiss_i,
    input  logic [PC_W-1:0] dmiss_pc_i,
    input  logic [1:0]      fill_done_i,
    input  logic [PC_W-1:0] next_pc_i,
    output logic [PC_W-1:0] fetch_pc_o,
    output logic            fetch_valid_o,
    output logic            active_tid_o,
    output logic [3:0]      squash_o
);
    tid_t            act;
    logic            run;
    logic            imiss_take;
    logic            dmiss_vld;
    tid_t            dmiss_tid;
    logic [NTHR-1:0] set_wait;
    logic [NTHR-1:0] thr_wait;
    logic [PC_W-1:0] thr_pc [NTHR];
    logic [NSQ-1:0]  squash;
    slot_t           if_slot;

    assign if_slot.vld = run;
    assign if_slot.tid = act;

    cgmt_sched u_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .dmiss_vld_i  (dmiss_vld),
        .dmiss_tid_i  (dmiss_tid),
        .imiss_i      (imiss_i),
        .fill_i       (fill_done_i),
        .wait_i       (thr_wait),
        .act_o        (act),
        .run_o        (run),
        .imiss_take_o (imiss_take),
        .set_wait_o   (set_wait)
    );

    cgmt_stage_tags u_tags (
        .clk          (clk),
        .rst_n        (rst_n),
        .if_slot_i    (if_slot),
        .dmiss_i      (dmiss_i),
        .imiss_take_i (imiss_take),
        .dmiss_vld_o  (dmiss_vld),
        .dmiss_tid_o  (dmiss_tid),
        .squash_o     (squash)
    );

    genvar t;
    generate
        for (t = 0; t < NTHR; t++) begin : g_ctx
            localparam logic [PC_W-1:0] RPC = (t == 0) ? RST_PC0 : RST_PC1;
            logic adv;
            logic cap;

            assign adv = run && (act == tid_t'(t)) && !squash[SQ_IF];
            assign cap = dmiss_vld && (dmiss_tid == tid_t'(t));

            cgmt_thread_ctx #(
                .PC_W   (PC_W),
                .RST_PC (RPC)
            ) u_ctx (
                .clk        (clk),
                .rst_n      (rst_n),
                .adv_i      (adv),
                .next_pc_i  (next_pc_i),
                .cap_i      (cap),
                .cap_pc_i   (dmiss_pc_i),
                .set_wait_i (set_wait[t]),
                .fill_i     (fill_done_i[t]),
                .pc_o       (thr_pc[t]),
                .wait_o     (thr_wait[t])
            );
        end
    endgenerate

    assign fetch_pc_o    = thr_pc[act];
    assign fetch_valid_o = run;
    assign active_tid_o  = act;
    assign squash_o      = squash;
endmodule

// File: rtl/cgmt_switch_ctrl_chk.sv
// Port-level properties of the switch controller, attached by bind.
module cgmt_switch_ctrl_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            imiss_i,
    input logic            dmiss_i,
    input logic [PC_W-1:0] next_pc_i,
    input logic [PC_W-1:0] fetch_pc_o,
    input logic            fetch_valid_o,
    input logic            active_tid_o,
    input logic [3:0]      squash_o
);
    // R2: an unaborted fetch is followed by the supplied next address
    p_seq_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_o && !squash_o[0]) |=> (fetch_pc_o == $past(next_pc_i)));

    // R8: without an abort of its own fetch, the owner keeps running
    p_no_preempt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_o && !squash_o[0]) |=> (fetch_valid_o && active_tid_o == $past(active_tid_o)));

    // R3: an instruction miss on a real fetch always aborts IF
    p_imiss_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_o && imiss_i) |-> squash_o[0]);

    // R4: a MEM abort only happens with a reported data miss
    p_mem_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o[3] |-> dmiss_i);

    // R4: ID or EX aborts only accompany a MEM abort
    p_shadow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_o[2] || squash_o[1]) |-> squash_o[3]);

    // R9: an idle fetch slot is never aborted
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid_o |-> !squash_o[0]);
endmodule

bind cgmt_switch_ctrl cgmt_switch_ctrl_chk #(.PC_W(PC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .imiss_i       (imiss_i),
    .dmiss_i       (dmiss_i),
    .next_pc_i     (next_pc_i),
    .fetch_pc_o    (fetch_pc_o),
    .fetch_valid_o (fetch_valid_o),
    .active_tid_o  (active_tid_o),
    .squash_o      (squash_o)
);

// File: tb/sim_cgmt_switch_ctrl.sv
module sim_cgmt_switch_ctrl;
    localparam logic [31:0] PC0 = 32'h0000_1000;
    localparam logic [31:0] PC1 = 32'h0000_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imiss = 1'b0;
    logic        dmiss = 1'b0;
    logic [31:0] dmiss_pc = '0;
    logic [1:0]  fill = 2'b00;
    logic [31:0] next_pc;
    logic [31:0] fetch_pc;
    logic        fetch_valid;
    logic        tid;
    logic [3:0]  squash;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign next_pc = fetch_pc + 32'd4;

    cgmt_switch_ctrl #(.PC_W(32), .RST_PC0(PC0), .RST_PC1(PC1)) u0 (
        .clk(clk), .rst_n(rst_n), .imiss_i(imiss), .dmiss_i(dmiss),
        .dmiss_pc_i(dmiss_pc), .fill_done_i(fill), .next_pc_i(next_pc),
        .fetch_pc_o(fetch_pc), .fetch_valid_o(fetch_valid),
        .active_tid_o(tid), .squash_o(squash)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Checks the fetch triple of the current cycle
    task automatic chk_fetch(input string req, input logic v, input logic t, input logic [31:0] pc);
        chk({req, " valid"}, {31'd0, fetch_valid}, {31'd0, v});
        if (v) begin
            chk({req, " tid"}, {31'd0, tid}, {31'd0, t});
            chk({req, " pc"}, fetch_pc, pc);
        end
    endtask

    // Move to the next cycle and clear pulse inputs
    task automatic nxt();
        @(posedge clk);
        #1;
        imiss = 1'b0; dmiss = 1'b0; fill = 2'b00; dmiss_pc = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        imiss = 1'b0; dmiss = 1'b0; fill = 2'b00; dmiss_pc = '0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset_seq();
        do_reset();
        chk_fetch("R1 reset", 1'b1, 1'b0, PC0);
        chk("R1 squash", {28'd0, squash}, 32'd0);
        nxt(); #1; chk_fetch("R2 seq1", 1'b1, 1'b0, PC0 + 4);
        nxt(); #1; chk_fetch("R2 seq2", 1'b1, 1'b0, PC0 + 8);
    endtask

    task automatic t_imiss();
        do_reset();
        imiss = 1'b1; #1;
        chk("R3 imiss squash", {28'd0, squash}, 32'h1);
        nxt(); #1; chk_fetch("R3 switch to t1", 1'b1, 1'b1, PC1);
        fill = 2'b01;
        nxt(); #1; chk_fetch("R8 no preempt", 1'b1, 1'b1, PC1 + 4);
        imiss = 1'b1;
        nxt(); #1; chk_fetch("R3 resume missed pc", 1'b1, 1'b0, PC0);
    endtask

    task automatic t_dmiss();
        do_reset();
        nxt(); nxt(); nxt();
        dmiss = 1'b1; dmiss_pc = PC0; #1;
        chk("R4 full shadow squash", {28'd0, squash}, 32'hF);
        nxt(); #1; chk_fetch("R1 t1 start", 1'b1, 1'b1, PC1);
        nxt(); imiss = 1'b1; #1;
        chk("R4 no stale shadow", {28'd0, squash}, 32'h1);
        nxt(); #1; chk_fetch("R9 idle", 1'b0, 1'b0, '0);
        fill = 2'b01;
        nxt(); #1; chk_fetch("R5 replay load", 1'b1, 1'b0, PC0);
    endtask

    task automatic t_prio();
        do_reset();
        nxt(); nxt(); nxt();
        dmiss = 1'b1; dmiss_pc = PC0; imiss = 1'b1; #1;
        chk("R7 squash", {28'd0, squash}, 32'hF);
        nxt(); #1; chk_fetch("R7 switch", 1'b1, 1'b1, PC1);
        imiss = 1'b1;
        nxt(); #1; chk_fetch("R9 idle", 1'b0, 1'b0, '0);
        fill = 2'b01;
        nxt(); #1; chk_fetch("R7 data pc wins", 1'b1, 1'b0, PC0);
    endtask

    task automatic t_empty();
        do_reset();
        dmiss = 1'b1; dmiss_pc = 32'hDEAD_0000; #1;
        chk("R6 no squash", {28'd0, squash}, 32'd0);
        nxt(); #1; chk_fetch("R6 no switch", 1'b1, 1'b0, PC0 + 4);
        imiss = 1'b1;
        nxt(); #1; imiss = 1'b1;
        nxt(); #1; chk_fetch("R9 idle", 1'b0, 1'b0, '0);
        fill = 2'b01;
        nxt(); #1; chk_fetch("R6 pc untouched", 1'b1, 1'b0, PC0 + 4);
    endtask

    task automatic t_cross();
        do_reset();
        nxt(); nxt();
        imiss = 1'b1; #1;
        chk("R3 squash", {28'd0, squash}, 32'h1);
        nxt(); #1;
        dmiss = 1'b1; dmiss_pc = PC0; #1;
        chk("R4 cross-thread squash", {28'd0, squash}, 32'hC);
        chk_fetch("R5 t1 running", 1'b1, 1'b1, PC1);
        nxt(); #1; chk_fetch("R5 no switch", 1'b1, 1'b1, PC1 + 4);
        imiss = 1'b1;
        nxt(); #1; chk_fetch("R9 idle", 1'b0, 1'b0, '0);
        fill = 2'b01;
        nxt(); #1; chk_fetch("R5 resume moved back", 1'b1, 1'b0, PC0);
    endtask

    task automatic t_wake();
        do_reset();
        imiss = 1'b1;
        nxt(); #1; imiss = 1'b1;
        nxt(); #1; chk_fetch("R9 idle", 1'b0, 1'b0, '0);
        chk("R9 idle squash", {28'd0, squash}, 32'd0);
        fill = 2'b11;
        nxt(); #1; chk_fetch("R9 tie to t0", 1'b1, 1'b0, PC0);
        imiss = 1'b1;
        nxt(); #1; chk_fetch("R9 t1 released", 1'b1, 1'b1, PC1);
    endtask

    initial begin
        t_reset_seq();
        t_imiss();
        t_dmiss();
        t_prio();
        t_empty();
        t_cross();
        t_wake();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule